// File: doc/BRIEF.md
# SD/MMC Command Path Engine

This block puts one host command onto the card command line of an SD or MMC card and, when asked, captures the card's reply. A controller first loads a 32-bit argument and then writes a command word. The command word holds the command index and three control bits. Setting the enable bit starts the engine. It then shifts a 48-bit frame out of the line, one bit per card clock. The frame carries a CRC7. After the frame the engine either finishes at once or releases the line and waits for the card to answer.

A reply is either a short 48-bit frame or a long 136-bit frame. Its contents are placed in four 32-bit response words. Four sticky flags report the outcome: command sent, response ended, timeout and CRC failure. Each flag stays set until a clear strobe with the matching mask bit removes it. Writing the command word with the enable bit low aborts any command in flight. The block runs on the card clock. It drives the line through a separate output-enable, so an external pad with a pull-up can release it.

Top module: `sdcmd_engine`

## Requirements
- R1: After a synchronous reset the line is released (`cmd_line_oe` low), `busy` is low, all four flags are low and all four response words read zero.
- R2: Command word layout is: bits 5:0 the index, bit 6 "response expected", bit 7 "long response", bit 8 enable. A write with bit 8 set starts transmission in the next cycle. The frame is 48 bits, sent MSB first at one bit per clock, in this order:
  - a 0 start bit
  - a 1 transmission bit
  - the 6-bit index
  - the 32-bit argument
  - a CRC7 (polynomial x^7+x^3+1, zero seed) over the preceding 40 bits
  - a 1 end bit
- R3: `cmd_line_oe` is high for exactly the 48 frame cycles and low at every other time.
- R4: With no response expected, `flag_sent` rises and `busy` falls in the cycle after the end bit. With a response expected, `flag_sent` is not set.
- R5: With a response expected, the engine looks for a 0 start bit on `cmd_line_in` for up to TMO_CYCLES (64) cycles after the end bit. A start bit seen in the last of those cycles is accepted. Otherwise `flag_timeout` sets and the engine goes idle, and any later reply is ignored.
- R6: For a short response, the 32 bits that follow the start bit, the transmission bit and the 6 index bits go to `rsp_word0`. Words 1 to 3 become zero. `flag_rsp_end` sets in the cycle after the last bit.
- R7: For a short response, a CRC7 is computed over its first 40 bits. If it differs from the 7 bits before the end bit, `flag_crc_fail` sets together with `flag_rsp_end`, and `rsp_word0` is still loaded.
- R8: For a long response, the 128 bits after the 8 header bits are stored with the first-received 32 bits in `rsp_word0` and the last 32 bits (which include the end bit) in `rsp_word3`. No CRC check is done and `flag_crc_fail` is not set.
- R9: Writing the command word with bit 8 clear returns the engine to idle in the next cycle. The line is released and no flag is set. The engine accepts a new command afterwards.
- R10: Flags are sticky. A `clr_wr` pulse clears those flags whose bit in `clr_mask` is 1 (bit 0 sent, bit 1 response end, bit 2 timeout, bit 3 CRC fail) and leaves the others set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock; one line bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| arg_wr | input | 1 | Load strobe for the argument register |
| arg_data | input | 32 | Argument value |
| cmd_wr | input | 1 | Write strobe for the command word |
| cmd_data | input | 9 | Command word: index, response, long, enable |
| clr_wr | input | 1 | Flag clear strobe |
| clr_mask | input | 4 | Flags to clear, one bit each |
| cmd_line_in | input | 1 | Sampled command line |
| cmd_line_out | output | 1 | Value driven on the command line |
| cmd_line_oe | output | 1 | Drive enable for the command line |
| busy | output | 1 | Engine is not idle |
| flag_sent | output | 1 | Sticky: command sent, no response expected |
| flag_rsp_end | output | 1 | Sticky: response fully received |
| flag_timeout | output | 1 | Sticky: no start bit in the response window |
| flag_crc_fail | output | 1 | Sticky: short-response CRC mismatch |
| rsp_word0 | output | 32 | Response word 0 (first received) |
| rsp_word1 | output | 32 | Response word 1 |
| rsp_word2 | output | 32 | Response word 2 |
| rsp_word3 | output | 32 | Response word 3 (last received) |

## Verification
Some properties are checked on every cycle:
- flags never drop without a clear strobe
- the line is already released when the sent flag rises
- the first driven bit after a load is a 0
- an abort or a timeout leaves the engine idle
- a long reply never raises the CRC flag

Other behaviour only the scenarios can show:
- exact frame contents against known CRC values
- the edge of the 64-cycle response window on both sides
- placement of short and long payloads in the response words
- selective clearing
- a reply arriving after a timeout or an abort being ignored

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

    localparam int IDX_W     = 6;
    localparam int ARG_W     = 32;
    localparam int CMD_W     = IDX_W + 3;
    localparam int HDR_W     = 2 + IDX_W + ARG_W;
    localparam int CRC_W     = 7;
    localparam int TX_LEN    = HDR_W + CRC_W + 1;
    localparam int SHORT_LEN = 48;
    localparam int LONG_LEN  = 136;
    localparam int RSP_W     = 128;
    localparam int RSP_WORDS = RSP_W / ARG_W;
    localparam int FLAG_W    = 4;

    localparam int FL_SENT = 0;
    localparam int FL_REND = 1;
    localparam int FL_TMO  = 2;
    localparam int FL_CRC  = 3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEND,
        ST_WAIT,
        ST_RECV
    } cmd_state_e;

    typedef struct packed {
        logic             go;
        logic             long_rsp;
        logic             want_rsp;
        logic [IDX_W-1:0] idx;
    } cmd_word_t;

    function automatic logic [CRC_W-1:0] crc7_calc(input logic [HDR_W-1:0] bits);
        logic [CRC_W-1:0] c;
        logic             fb;
        c = '0;
        for (int i = HDR_W - 1; i >= 0; i--) begin
            fb = bits[i] ^ c[CRC_W-1];
            c  = {c[CRC_W-2:0], 1'b0};
            if (fb) c = c ^ 7'h09;
        end
        return c;
    endfunction

endpackage

// File: rtl/sdcmd_tx.sv
module sdcmd_tx
    import sdcmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [IDX_W-1:0] idx,
    input  logic [ARG_W-1:0] arg,
    input  logic             active,
    output logic             line_bit,
    output logic             last
);
    localparam int CNT_W = $clog2(TX_LEN);

    logic [TX_LEN-1:0] sh;
    logic [CNT_W-1:0]  cnt;
    logic [HDR_W-1:0]  head;

    assign head = {1'b0, 1'b1, idx, arg};

    always_ff @(posedge clk) begin
        if (rst) begin
            sh  <= '1;
            cnt <= '0;
        end else if (load) begin
            sh  <= {head, crc7_calc(head), 1'b1};
            cnt <= CNT_W'(TX_LEN - 1);
        end else if (active) begin
            sh <= {sh[TX_LEN-2:0], 1'b1};
            if (cnt != '0) cnt <= cnt - 1'b1;
        end
    end

    assign line_bit = sh[TX_LEN-1];
    assign last     = (cnt == '0);

    a_r2_start_bit: assert property (@(posedge clk) disable iff (rst)
        load |=> !line_bit);

endmodule

// File: rtl/sdcmd_rx.sv
module sdcmd_rx
    import sdcmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             shift,
    input  logic             line_in,
    output logic [RSP_W-1:0] payload,
    output logic             crc_bad
);
    logic [RSP_W-2:0] sh;

    always_ff @(posedge clk) begin
        if (rst)        sh <= '0;
        else if (shift) sh <= {sh[RSP_W-3:0], line_in};
    end

    assign payload = {sh, line_in};
    assign crc_bad = crc7_calc(payload[SHORT_LEN-1 -: HDR_W]) != payload[CRC_W:1];

endmodule

// File: rtl/sdcmd_fsm.sv
module sdcmd_fsm
    import sdcmd_pkg::*;
#(
    parameter int TMO_CYCLES = 64
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      cmd_wr,
    input  cmd_word_t word,
    input  logic      tx_last,
    input  logic      line_in,
    output logic      busy,
    output logic      tx_load,
    output logic      tx_active,
    output logic      rx_shift,
    output logic      rx_done,
    output logic      rsp_long,
    output logic      set_sent,
    output logic      set_tmo
);
    localparam int TMO_W = $clog2(TMO_CYCLES);
    localparam int RXC_W = $clog2(LONG_LEN);
    localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TMO_CYCLES - 1);

    cmd_state_e       st;
    logic [TMO_W-1:0] tmo_cnt;
    logic [RXC_W-1:0] rx_cnt;
    logic             want_q;
    logic             long_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            tmo_cnt <= '0;
            rx_cnt  <= '0;
            want_q  <= 1'b0;
            long_q  <= 1'b0;
        end else if (cmd_wr) begin
            tmo_cnt <= '0;
            if (word.go) begin
                st     <= ST_SEND;
                want_q <= word.want_rsp;
                long_q <= word.long_rsp;
            end else begin
                st <= ST_IDLE;
            end
        end else begin
            case (st)
                ST_SEND: if (tx_last) begin
                    st      <= want_q ? ST_WAIT : ST_IDLE;
                    tmo_cnt <= '0;
                end
                ST_WAIT: if (!line_in) begin
                    st     <= ST_RECV;
                    rx_cnt <= long_q ? RXC_W'(LONG_LEN - 2) : RXC_W'(SHORT_LEN - 2);
                end else if (tmo_cnt == TMO_LAST) begin
                    st <= ST_IDLE;
                end else begin
                    tmo_cnt <= tmo_cnt + 1'b1;
                end
                ST_RECV: if (rx_cnt == '0) st <= ST_IDLE;
                         else rx_cnt <= rx_cnt - 1'b1;
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy      = (st != ST_IDLE);
    assign tx_load   = cmd_wr && word.go;
    assign tx_active = (st == ST_SEND);
    assign rx_shift  = ((st == ST_WAIT) && !line_in) || (st == ST_RECV);
    assign rx_done   = (st == ST_RECV) && (rx_cnt == '0) && !cmd_wr;
    assign set_sent  = (st == ST_SEND) && tx_last && !want_q && !cmd_wr;
    assign set_tmo   = (st == ST_WAIT) && line_in && (tmo_cnt == TMO_LAST) && !cmd_wr;
    assign rsp_long  = long_q;

    a_r9_abort_idle: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && !word.go) |=> !busy);

    a_r5_timeout_idle: assert property (@(posedge clk) disable iff (rst)
        set_tmo |=> (!busy && !tx_active));

endmodule

// File: rtl/sdcmd_engine.sv
module sdcmd_engine
    import sdcmd_pkg::*;
#(
    parameter int TMO_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arg_wr,
    input  logic [ARG_W-1:0]  arg_data,
    input  logic              cmd_wr,
    input  logic [CMD_W-1:0]  cmd_data,
    input  logic              clr_wr,
    input  logic [FLAG_W-1:0] clr_mask,
    input  logic              cmd_line_in,
    output logic              cmd_line_out,
    output logic              cmd_line_oe,
    output logic              busy,
    output logic              flag_sent,
    output logic              flag_rsp_end,
    output logic              flag_timeout,
    output logic              flag_crc_fail,
    output logic [ARG_W-1:0]  rsp_word0,
    output logic [ARG_W-1:0]  rsp_word1,
    output logic [ARG_W-1:0]  rsp_word2,
    output logic [ARG_W-1:0]  rsp_word3
);
    cmd_word_t         word;
    logic [ARG_W-1:0]  arg_q;
    logic              tx_load, tx_active, tx_bit, tx_last;
    logic              rx_shift, rx_done, rsp_long, crc_bad;
    logic              set_sent, set_tmo;
    logic [RSP_W-1:0]  payload;
    logic [FLAG_W-1:0] flags_q, flag_set, clr_vec;
    logic [ARG_W-1:0]  rsp_q [RSP_WORDS];

    assign word = cmd_data;

    always_ff @(posedge clk) begin
        if (rst)         arg_q <= '0;
        else if (arg_wr) arg_q <= arg_data;
    end

    sdcmd_fsm #(.TMO_CYCLES(TMO_CYCLES)) u_fsm (
        .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .word(word),
        .tx_last(tx_last), .line_in(cmd_line_in), .busy(busy),
        .tx_load(tx_load), .tx_active(tx_active), .rx_shift(rx_shift),
        .rx_done(rx_done), .rsp_long(rsp_long), .set_sent(set_sent),
        .set_tmo(set_tmo)
    );

    sdcmd_tx u_tx (
        .clk(clk), .rst(rst), .load(tx_load), .idx(word.idx), .arg(arg_q),
        .active(tx_active), .line_bit(tx_bit), .last(tx_last)
    );

    sdcmd_rx u_rx (
        .clk(clk), .rst(rst), .shift(rx_shift), .line_in(cmd_line_in),
        .payload(payload), .crc_bad(crc_bad)
    );

    assign cmd_line_oe  = tx_active;
    assign cmd_line_out = tx_active ? tx_bit : 1'b1;

    always_comb begin
        flag_set          = '0;
        flag_set[FL_SENT] = set_sent;
        flag_set[FL_REND] = rx_done;
        flag_set[FL_TMO]  = set_tmo;
        flag_set[FL_CRC]  = rx_done && !rsp_long && crc_bad;
        clr_vec           = clr_wr ? clr_mask : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= (flags_q & ~clr_vec) | flag_set;
    end

    assign flag_sent     = flags_q[FL_SENT];
    assign flag_rsp_end  = flags_q[FL_REND];
    assign flag_timeout  = flags_q[FL_TMO];
    assign flag_crc_fail = flags_q[FL_CRC];

    for (genvar k = 0; k < RSP_WORDS; k++) begin : g_rsp
        logic [ARG_W-1:0] short_val;
        if (k == 0) begin : g_first
            assign short_val = payload[SHORT_LEN-IDX_W-3 -: ARG_W];
        end else begin : g_rest
            assign short_val = '0;
        end
        always_ff @(posedge clk) begin
            if (rst)          rsp_q[k] <= '0;
            else if (rx_done) rsp_q[k] <= rsp_long ? payload[RSP_W-1-k*ARG_W -: ARG_W] : short_val;
        end
    end

    assign rsp_word0 = rsp_q[0];
    assign rsp_word1 = rsp_q[1];
    assign rsp_word2 = rsp_q[2];
    assign rsp_word3 = rsp_q[3];

    a_r10_sticky_flags: assert property (@(posedge clk) disable iff (rst)
        !clr_wr |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

    a_r4_sent_released: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_sent) |-> !cmd_line_oe);

    a_r8_long_no_crc: assert property (@(posedge clk) disable iff (rst)
        (rx_done && rsp_long && !flag_crc_fail) |=> !flag_crc_fail);

endmodule

// File: tb/sdcmd_engine_test.sv
module sdcmd_engine_test;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        arg_wr = 1'b0;
    logic [31:0] arg_data = '0;
    logic        cmd_wr = 1'b0;
    logic [8:0]  cmd_data = '0;
    logic        clr_wr = 1'b0;
    logic [3:0]  clr_mask = '0;
    logic        cmd_line_in = 1'b1;
    logic        cmd_line_out, cmd_line_oe, busy;
    logic        flag_sent, flag_rsp_end, flag_timeout, flag_crc_fail;
    logic [31:0] rsp_word0, rsp_word1, rsp_word2, rsp_word3;

    int n_checks = 0;
    int n_err    = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sdcmd_engine uut (
        .clk(clk), .rst(rst), .arg_wr(arg_wr), .arg_data(arg_data),
        .cmd_wr(cmd_wr), .cmd_data(cmd_data), .clr_wr(clr_wr), .clr_mask(clr_mask),
        .cmd_line_in(cmd_line_in), .cmd_line_out(cmd_line_out), .cmd_line_oe(cmd_line_oe),
        .busy(busy), .flag_sent(flag_sent), .flag_rsp_end(flag_rsp_end),
        .flag_timeout(flag_timeout), .flag_crc_fail(flag_crc_fail),
        .rsp_word0(rsp_word0), .rsp_word1(rsp_word1), .rsp_word2(rsp_word2),
        .rsp_word3(rsp_word3)
    );

    // index, argument, known CRC7 of the command frame
    localparam logic [44:0] VEC [4] = '{
        {6'd0,  32'h0000_0000, 7'h4A},
        {6'd8,  32'h0000_01AA, 7'h43},
        {6'd55, 32'h0000_0000, 7'h32},
        {6'd41, 32'h4000_0000, 7'h3B}
    };

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [6:0] ref_crc(input logic [39:0] d);
        logic [6:0] r;
        r = '0;
        for (int i = 39; i >= 0; i--) begin
            logic b;
            b = d[i] ^ r[6];
            r = {r[5:3], r[2] ^ b, r[1:0], b};
        end
        return r;
    endfunction

    task automatic issue(input logic [5:0] idx, input logic [31:0] a,
                         input logic want, input logic lng);
        arg_wr = 1'b1; arg_data = a;
        @(negedge clk);
        arg_wr = 1'b0;
        cmd_wr = 1'b1; cmd_data = {1'b1, lng, want, idx};
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    task automatic capture(output logic [47:0] f, output logic oe_all);
        oe_all = 1'b1;
        for (int i = 47; i >= 0; i--) begin
            f[i]   = cmd_line_out;
            oe_all = oe_all & cmd_line_oe;
            @(negedge clk);
        end
    endtask

    task automatic drive_rsp(input logic [135:0] bits, input int len, input int dly);
        cmd_line_in = 1'b1;
        repeat (dly) @(negedge clk);
        for (int i = len - 1; i >= 0; i--) begin
            cmd_line_in = bits[i];
            @(negedge clk);
        end
        cmd_line_in = 1'b1;
    endtask

    task automatic clear(input logic [3:0] m);
        clr_wr = 1'b1; clr_mask = m;
        @(negedge clk);
        clr_wr = 1'b0; clr_mask = '0;
    endtask

    task automatic abort_cmd();
        cmd_wr = 1'b1; cmd_data = '0;
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        logic [47:0]  fr;
        logic         oe_all;
        logic [39:0]  hdr;
        logic [127:0] pl;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk(!cmd_line_oe, "R1", "oe", cmd_line_oe, 0);
        chk(!busy, "R1", "busy", busy, 0);
        chk({flag_crc_fail, flag_timeout, flag_rsp_end, flag_sent} == 4'h0, "R1", "flags",
            {flag_crc_fail, flag_timeout, flag_rsp_end, flag_sent}, 0);
        chk({rsp_word0, rsp_word1, rsp_word2, rsp_word3} == '0, "R1", "rsp",
            {rsp_word0, rsp_word1, rsp_word2, rsp_word3}, 0);

        // R2 R3 R4: table of commands with no response
        for (int v = 0; v < 4; v++) begin
            logic [47:0] exp_fr;
            exp_fr = {1'b0, 1'b1, VEC[v][44:39], VEC[v][38:7], VEC[v][6:0], 1'b1};
            issue(VEC[v][44:39], VEC[v][38:7], 1'b0, 1'b0);
            capture(fr, oe_all);
            chk(fr == exp_fr, "R2", "frame", fr, exp_fr);
            chk(oe_all, "R3", "oe during frame", oe_all, 1);
            chk(!cmd_line_oe, "R3", "oe after frame", cmd_line_oe, 0);
            chk(flag_sent && !busy, "R4", "sent/idle", {flag_sent, busy}, 2'b10);
            chk(!flag_rsp_end, "R4", "no rsp_end", flag_rsp_end, 0);
            clear(4'hF);
        end

        // R8 long response
        issue(6'd2, 32'h0, 1'b1, 1'b1);
        capture(fr, oe_all);
        chk(!flag_sent && busy, "R4", "no sent when response expected", {flag_sent, busy}, 2'b01);
        pl = {32'h1111_2222, 32'h3333_4444, 32'h5555_6666, 32'h7777_8889};
        drive_rsp({2'b00, 6'h3F, pl}, 136, 3);
        chk(flag_rsp_end && !busy, "R8", "rsp_end", {flag_rsp_end, busy}, 2'b10);
        chk({rsp_word0, rsp_word1, rsp_word2, rsp_word3} == pl, "R8", "words",
            {rsp_word0, rsp_word1, rsp_word2, rsp_word3}, pl);
        chk(!flag_crc_fail, "R8", "no crc fail", flag_crc_fail, 0);
        clear(4'hF);

        // R6 short response with good CRC
        issue(6'd17, 32'h0000_1234, 1'b1, 1'b0);
        capture(fr, oe_all);
        hdr = {2'b00, 6'd17, 32'hCAFE_F00D};
        drive_rsp({88'h0, hdr, ref_crc(hdr), 1'b1}, 48, 5);
        chk(flag_rsp_end && !busy, "R6", "rsp_end", {flag_rsp_end, busy}, 2'b10);
        chk(rsp_word0 == 32'hCAFE_F00D, "R6", "word0", rsp_word0, 32'hCAFE_F00D);
        chk({rsp_word1, rsp_word2, rsp_word3} == '0, "R6", "upper words zero",
            {rsp_word1, rsp_word2, rsp_word3}, 0);
        chk(!flag_crc_fail, "R7", "good crc", flag_crc_fail, 0);
        clear(4'hF);

        // R7 short response with bad CRC
        issue(6'd13, 32'h0, 1'b1, 1'b0);
        capture(fr, oe_all);
        hdr = {2'b00, 6'd13, 32'h0000_0900};
        drive_rsp({88'h0, hdr, ref_crc(hdr) ^ 7'h01, 1'b1}, 48, 0);
        chk(flag_crc_fail && flag_rsp_end, "R7", "crc fail + end",
            {flag_crc_fail, flag_rsp_end}, 2'b11);
        chk(rsp_word0 == 32'h0000_0900, "R7", "word0 loaded", rsp_word0, 32'h0000_0900);

        // R10 selective clear
        clear(4'b0010);
        chk(!flag_rsp_end && flag_crc_fail, "R10", "clear only rsp_end",
            {flag_rsp_end, flag_crc_fail}, 2'b01);
        clear(4'b1000);
        chk(!flag_crc_fail, "R10", "clear crc", flag_crc_fail, 0);

        // R5 start bit in the last cycle of the window is accepted
        issue(6'd13, 32'h0, 1'b1, 1'b0);
        capture(fr, oe_all);
        hdr = {2'b00, 6'd13, 32'h0000_0A00};
        drive_rsp({88'h0, hdr, ref_crc(hdr), 1'b1}, 48, 63);
        chk(flag_rsp_end && !flag_timeout, "R5", "late start accepted",
            {flag_rsp_end, flag_timeout}, 2'b10);
        clear(4'hF);

        // R5 timeout after 64 idle cycles, later reply ignored
        issue(6'd13, 32'h0, 1'b1, 1'b0);
        capture(fr, oe_all);
        repeat (63) @(negedge clk);
        chk(!flag_timeout && busy, "R5", "window still open", {flag_timeout, busy}, 2'b01);
        @(negedge clk);
        chk(flag_timeout && !busy, "R5", "timeout", {flag_timeout, busy}, 2'b10);
        drive_rsp({88'h0, hdr, ref_crc(hdr), 1'b1}, 48, 0);
        chk(!flag_rsp_end && !busy, "R5", "late reply ignored", {flag_rsp_end, busy}, 2'b00);
        clear(4'hF);

        // R9 abort during transmission
        issue(6'd5, 32'hFFFF_FFFF, 1'b0, 1'b0);
        repeat (10) @(negedge clk);
        abort_cmd();
        chk(!cmd_line_oe && !busy, "R9", "abort in send", {cmd_line_oe, busy}, 2'b00);
        repeat (60) @(negedge clk);
        chk(!flag_sent, "R9", "no sent after abort", flag_sent, 0);

        // R9 abort while waiting for response
        issue(6'd5, 32'h0, 1'b1, 1'b0);
        capture(fr, oe_all);
        repeat (10) @(negedge clk);
        abort_cmd();
        chk(!busy, "R9", "abort in wait", busy, 0);
        repeat (80) @(negedge clk);
        chk({flag_crc_fail, flag_timeout, flag_rsp_end, flag_sent} == 4'h0, "R9", "no flags",
            {flag_crc_fail, flag_timeout, flag_rsp_end, flag_sent}, 0);

        // R9 new command after abort
        issue(VEC[1][44:39], VEC[1][38:7], 1'b0, 1'b0);
        capture(fr, oe_all);
        chk(fr == {1'b0, 1'b1, VEC[1][44:39], VEC[1][38:7], VEC[1][6:0], 1'b1}, "R9",
            "frame after abort", fr, {1'b0, 1'b1, VEC[1][44:39], VEC[1][38:7], VEC[1][6:0], 1'b1});
        chk(flag_sent, "R9", "sent after restart", flag_sent, 1);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule